// File: doc/BRIEF.md
# Configuration Access Arbiter

This block lets two requesters share one configuration register store. The first requester is a local management port driven by application logic. The second is a path that carries configuration requests already decoded from the link. Link requests always take precedence. A local read or write is never refused. The block captures it with its address, write data and target selector, and keeps it until a cycle comes in which no link request is pending. It then performs the access and pulses a one-cycle acknowledge. For a read, the same cycle presents the read data.

Each access goes to one of two register banks, chosen by the top bit of a 9-bit selector. One is a core bank. The other is a set of per-function banks indexed by the low eight selector bits. Every modeled register has a per-bit writable mask that applies equally to both requesters, so read-only bits keep their reset values whatever either side writes. The link request channel has a valid signal and no ready: it is never back-pressured, and it is accepted in every cycle that valid is high. The local port is a plain enable interface that allows one operation at a time.

Top module: `cfgarb_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `lm_ack`, `lk_rsp_valid`, `lm_rdata` and `lk_rsp_rdata` are all zero.
- R2: Addresses are 12-bit byte addresses of 32-bit registers, so the word index is `addr[11:2]` and bits [1:0] are ignored. A word index beyond the bank reads as zero, and a write to it changes nothing.
- R3: While `lk_req_valid` is high, no held local operation executes. It executes on the first rising edge at which `lk_req_valid` is low. With no link traffic, the acknowledge is high in the second cycle after the enable cycle.
- R4: `lm_ack` is high for exactly one cycle per local operation, and never in the cycle directly after an accepted enable.
- R5: In the acknowledge cycle of a local read, `lm_rdata` carries the register value. It keeps that value until the next local read is acknowledged. A local write does not change it.
- R6: When `sel[8]`=0, the access goes to the core bank (16 words) and `sel[7:0]` is ignored. When `sel[8]`=1, it goes to the bank of function `sel[7:0]` (4 functions, 8 words each). A function number of 4 or more reads as zero and ignores writes.
- R7: Core word i resets to 0xC0DE0000+i. Word 0 is fully read-only. In odd words only bits [15:0] are writable, and in even words from 2 upward only bits [31:16]. Word w of function f resets to 0x5A000000 + f*65536 + w, and only its bits [23:8] are writable. These masks apply to writes from both requesters.
- R8: A link request is accepted in every cycle in which it is valid. In the next cycle `lk_rsp_valid` is high for one cycle, and `lk_rsp_rdata` is the register value for a read or zero for a write.
- R9: Only one local operation may be outstanding. Read or write enables that arrive after an operation has been captured, and before its acknowledge, are ignored.
- R10: If `lm_rd_en` and `lm_wr_en` are both high in the accepting cycle, the operation is a write and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req_valid | input | 1 | Link configuration request pending this cycle |
| lk_req_write | input | 1 | Link request is a write (1) or a read (0) |
| lk_req_addr | input | 12 | Link request byte address |
| lk_req_sel | input | 9 | Link request bank/function selector |
| lk_req_wdata | input | 32 | Link write data |
| lk_rsp_valid | output | 1 | Link completion, one cycle after the request |
| lk_rsp_rdata | output | 32 | Link read data, zero for writes |
| lm_rd_en | input | 1 | Local read enable |
| lm_wr_en | input | 1 | Local write enable |
| lm_addr | input | 12 | Local byte address |
| lm_sel | input | 9 | Local bank/function selector |
| lm_wdata | input | 32 | Local write data |
| lm_ack | output | 1 | One-cycle completion of a local operation |
| lm_rdata | output | 32 | Local read data, valid with `lm_ack` |

## Verification
The assertions check on every cycle that:
- no held local operation executes while a link request is pending;
- the acknowledge is a single-cycle pulse that never follows directly on an accepted enable;
- a link completion appears only after a link request;
- the captured operation stays frozen while it waits.

The data content cannot be checked by the assertions and is left to the bench scenarios. These cover the masked writes from both sides, the bank and function decoding, reads outside a bank's range, the exact deferral latency under a link burst, ignored enables while busy, and write priority when both enables are high.

// File: rtl/cfgarb_pkg.sv
package cfgarb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int SEL_W  = 9;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] wdata;
  } cfg_req_t;

  // Reset value of a core-bank word
  function automatic logic [DATA_W-1:0] core_reset(int idx);
    return 32'hC0DE_0000 | 32'(idx);
  endfunction

  // Writable bits of a core-bank word
  function automatic logic [DATA_W-1:0] core_wmask(int idx);
    if (idx == 0)          return 32'h0000_0000;
    else if (idx % 2 == 1) return 32'h0000_FFFF;
    else                   return 32'hFFFF_0000;
  endfunction

  // Reset value of a per-function word
  function automatic logic [DATA_W-1:0] func_reset(int fn, int idx);
    return 32'h5A00_0000 | (32'(fn & 255) << 16) | 32'(idx & 255);
  endfunction

  // Writable bits of a per-function word
  function automatic logic [DATA_W-1:0] func_wmask(int idx);
    return (idx >= 0) ? 32'h00FF_FF00 : 32'h0;
  endfunction
endpackage

// File: rtl/cfgarb_regbank.sv
module cfgarb_regbank
  import cfgarb_pkg::*;
#(
  parameter int WORDS     = 16,
  parameter bit FUNC_BANK = 1'b0,
  parameter int FN        = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] widx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(WORDS)-1:0] ridx,
  output logic [DATA_W-1:0]        rdata
);
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] RST_V = FUNC_BANK ? func_reset(FN, w) : core_reset(w);
    localparam logic [DATA_W-1:0] WMASK = FUNC_BANK ? func_wmask(w) : core_wmask(w);
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= RST_V;
      else if (we && widx == IDX_W'(w))
        q <= (q & ~WMASK) | (wdata & WMASK);
    end

    assign words[w] = q;
  end

  assign rdata = words[ridx];
endmodule

// File: rtl/cfgarb_store.sv
module cfgarb_store
  import cfgarb_pkg::*;
#(
  parameter int CORE_WORDS = 16,
  parameter int FUNC_WORDS = 8,
  parameter int NUM_FUNCS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  cfg_req_t          acc_req,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CIDX_W = $clog2(CORE_WORDS);
  localparam int FIDX_W = $clog2(FUNC_WORDS);
  localparam int FN_W   = $clog2(NUM_FUNCS);

  logic [ADDR_W-1:0] word_idx;
  logic [7:0]        fn_num;
  logic              core_hit, func_hit, do_wr;
  logic [DATA_W-1:0] core_rd;
  logic [DATA_W-1:0] func_rd [NUM_FUNCS];

  // word index ignores the byte-offset bits
  assign word_idx = acc_req.addr >> 2;
  assign fn_num   = acc_req.sel[7:0];
  assign core_hit = !acc_req.sel[SEL_W-1] && (word_idx < ADDR_W'(CORE_WORDS));
  assign func_hit = acc_req.sel[SEL_W-1] && (fn_num < 8'(NUM_FUNCS))
                    && (word_idx < ADDR_W'(FUNC_WORDS));
  assign do_wr    = acc_en && acc_req.wr;

  cfgarb_regbank #(
    .WORDS(CORE_WORDS), .FUNC_BANK(1'b0), .FN(0)
  ) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (do_wr && core_hit),
    .widx (word_idx[CIDX_W-1:0]),
    .wdata(acc_req.wdata),
    .ridx (word_idx[CIDX_W-1:0]),
    .rdata(core_rd)
  );

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
    cfgarb_regbank #(
      .WORDS(FUNC_WORDS), .FUNC_BANK(1'b1), .FN(f)
    ) u_fbank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (do_wr && func_hit && fn_num == 8'(f)),
      .widx (word_idx[FIDX_W-1:0]),
      .wdata(acc_req.wdata),
      .ridx (word_idx[FIDX_W-1:0]),
      .rdata(func_rd[f])
    );
  end

  always_comb begin
    if (core_hit)      rd_data = core_rd;
    else if (func_hit) rd_data = func_rd[fn_num[FN_W-1:0]];
    else               rd_data = '0;
  end
endmodule

// File: rtl/cfgarb_local_hold.sv
module cfgarb_local_hold
  import cfgarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_pending,
  output logic              busy,
  output logic              exec,
  output cfg_req_t          held
);
  logic accept;

  assign accept = !busy && (rd_en || wr_en);
  assign exec   = busy && !link_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      held.wr    <= wr_en;   // write wins over a simultaneous read
      held.addr  <= addr;
      held.sel   <= sel;
      held.wdata <= wdata;
    end else if (exec) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgarb_top.sv
module cfgarb_top
  import cfgarb_pkg::*;
#(
  parameter int CORE_WORDS = 16,
  parameter int FUNC_WORDS = 8,
  parameter int NUM_FUNCS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_req_valid,
  input  logic        lk_req_write,
  input  logic [11:0] lk_req_addr,
  input  logic [8:0]  lk_req_sel,
  input  logic [31:0] lk_req_wdata,
  output logic        lk_rsp_valid,
  output logic [31:0] lk_rsp_rdata,
  input  logic        lm_rd_en,
  input  logic        lm_wr_en,
  input  logic [11:0] lm_addr,
  input  logic [8:0]  lm_sel,
  input  logic [31:0] lm_wdata,
  output logic        lm_ack,
  output logic [31:0] lm_rdata
);
  logic              busy, exec, acc_en;
  cfg_req_t          held, link_req, acc_req;
  logic [DATA_W-1:0] store_rd;

  cfgarb_local_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (lm_rd_en),
    .wr_en       (lm_wr_en),
    .addr        (lm_addr),
    .sel         (lm_sel),
    .wdata       (lm_wdata),
    .link_pending(lk_req_valid),
    .busy        (busy),
    .exec        (exec),
    .held        (held)
  );

  assign link_req = '{wr: lk_req_write, addr: lk_req_addr, sel: lk_req_sel, wdata: lk_req_wdata};
  // link always wins the single store port
  assign acc_en   = lk_req_valid || exec;
  assign acc_req  = lk_req_valid ? link_req : held;

  cfgarb_store #(
    .CORE_WORDS(CORE_WORDS), .FUNC_WORDS(FUNC_WORDS), .NUM_FUNCS(NUM_FUNCS)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (acc_en),
    .acc_req(acc_req),
    .rd_data(store_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      lk_rsp_rdata <= '0;
      lm_ack       <= 1'b0;
      lm_rdata     <= '0;
    end else begin
      lk_rsp_valid <= lk_req_valid;
      lk_rsp_rdata <= (lk_req_valid && !lk_req_write) ? store_rd : '0;
      lm_ack       <= exec;
      if (exec && !held.wr) lm_rdata <= store_rd;
    end
  end
endmodule

// File: rtl/cfgarb_checker.sv
module cfgarb_checker
  import cfgarb_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     lk_req_valid,
  input logic     lk_rsp_valid,
  input logic     lm_rd_en,
  input logic     lm_wr_en,
  input logic     lm_ack,
  input logic     busy,
  input logic     exec,
  input cfg_req_t held
);
  assert_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_valid |-> !exec);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !busy);

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lm_ack |=> !lm_ack);

  assert_ack_not_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (lm_rd_en || lm_wr_en)) |=> !lm_ack);

  assert_rsp_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid |-> $past(lk_req_valid));

  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(held));
endmodule

bind cfgarb_top cfgarb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_req_valid(lk_req_valid),
  .lk_rsp_valid(lk_rsp_valid),
  .lm_rd_en    (lm_rd_en),
  .lm_wr_en    (lm_wr_en),
  .lm_ack      (lm_ack),
  .busy        (busy),
  .exec        (exec),
  .held        (held)
);

// File: tb/tb_cfgarb_top.sv
module tb_cfgarb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic lk_req_valid = 0, lk_req_write = 0;
  logic [11:0] lk_req_addr = 0;
  logic [8:0]  lk_req_sel = 0;
  logic [31:0] lk_req_wdata = 0;
  logic lk_rsp_valid;
  logic [31:0] lk_rsp_rdata;
  logic lm_rd_en = 0, lm_wr_en = 0;
  logic [11:0] lm_addr = 0;
  logic [8:0]  lm_sel = 0;
  logic [31:0] lm_wdata = 0;
  logic lm_ack;
  logic [31:0] lm_rdata;

  int total = 0, failed = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgarb_top dut (.*);

  // ---------------- reference model ----------------
  logic [31:0] m_core [16];
  logic [31:0] m_fn [4][8];
  bit m_busy, h_wr, run_now;
  logic [11:0] h_addr; logic [8:0] h_sel; logic [31:0] h_d;
  logic e_ack, e_rv; logic [31:0] e_rd, e_rdd;

  function automatic logic [31:0] cmask(int i);
    if (i == 0) return 0;
    return (i % 2 == 1) ? 32'h0000FFFF : 32'hFFFF0000;
  endfunction

  function automatic logic [31:0] mread(logic [8:0] s, logic [11:0] a);
    int idx = int'(a) / 4;
    if (!s[8]) return (idx < 16) ? m_core[idx] : 32'h0;
    if (int'(s[7:0]) < 4 && idx < 8) return m_fn[s[7:0]][idx];
    return 32'h0;
  endfunction

  task automatic mwrite(logic [8:0] s, logic [11:0] a, logic [31:0] d);
    int idx = int'(a) / 4;
    if (!s[8]) begin
      if (idx < 16) m_core[idx] = (m_core[idx] & ~cmask(idx)) | (d & cmask(idx));
    end else if (int'(s[7:0]) < 4 && idx < 8) begin
      m_fn[s[7:0]][idx] = (m_fn[s[7:0]][idx] & ~32'h00FFFF00) | (d & 32'h00FFFF00);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_core[i] = 32'hC0DE0000 + i;
      for (int f = 0; f < 4; f++)
        for (int w = 0; w < 8; w++) m_fn[f][w] = 32'h5A000000 + f * 65536 + w;
      m_busy = 0; e_ack = 0; e_rv = 0; e_rd = 0; e_rdd = 0;
    end else begin
      run_now = m_busy && !lk_req_valid;
      e_rv  = lk_req_valid;
      e_rdd = (lk_req_valid && !lk_req_write) ? mread(lk_req_sel, lk_req_addr) : 32'h0;
      if (lk_req_valid && lk_req_write) mwrite(lk_req_sel, lk_req_addr, lk_req_wdata);
      e_ack = run_now;
      if (run_now) begin
        if (h_wr) mwrite(h_sel, h_addr, h_d);
        else e_rd = mread(h_sel, h_addr);
        m_busy = 0;
      end else if (!m_busy && (lm_rd_en || lm_wr_en)) begin
        m_busy = 1; h_wr = lm_wr_en; h_addr = lm_addr; h_sel = lm_sel; h_d = lm_wdata;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 ack", {31'b0, lm_ack}, {31'b0, e_ack});
      chk("R5 lm_rdata", lm_rdata, e_rd);
      chk("R8 rsp_valid", {31'b0, lk_rsp_valid}, {31'b0, e_rv});
      chk("R8 rsp_rdata", lk_rsp_rdata, e_rdd);
    end
  end

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; failed++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  task automatic lm_op(input bit rd, input bit wr, input logic [11:0] a, input logic [8:0] s,
                       input logic [31:0] d, output int lat, output logic [31:0] q);
    lm_rd_en = rd; lm_wr_en = wr; lm_addr = a; lm_sel = s; lm_wdata = d;
    @(negedge clk);
    lm_rd_en = 0; lm_wr_en = 0;
    lat = 1;
    while (!lm_ack && lat < 50) begin @(negedge clk); lat++; end
    q = lm_rdata;
    @(negedge clk);
  endtask

  task automatic lk_op(input bit wr, input logic [11:0] a, input logic [8:0] s,
                       input logic [31:0] d, input int n);
    lk_req_valid = 1; lk_req_write = wr; lk_req_addr = a; lk_req_sel = s; lk_req_wdata = d;
    repeat (n) @(negedge clk);
    lk_req_valid = 0; lk_req_write = 0;
  endtask

  initial begin
    int lat;
    logic [31:0] q;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack", {31'b0, lm_ack}, 32'h0);
    chk("R1 rsp", {31'b0, lk_rsp_valid}, 32'h0);
    chk("R1 rdata", lm_rdata | lk_rsp_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {31'b0, lm_ack} | lm_rdata, 32'h0);

    // R2 R6: low address bits and sel[7:0] ignored for the core bank
    lm_op(1, 0, 12'h00F, 9'h0FF, 0, lat, q);
    chk("R2 R6 core read", q, 32'hC0DE0003);
    chk("R4 latency", lat, 2);

    // R7: core word 0 is read-only to link writes
    lk_op(1, 12'h000, 9'h000, 32'hFFFFFFFF, 1);
    lm_op(1, 0, 12'h000, 9'h000, 0, lat, q);
    chk("R7 core ro", q, 32'hC0DE0000);

    // R7 R8: link write to even word, then link readback
    lk_op(1, 12'h008, 9'h000, 32'h12345678, 1);
    lk_op(0, 12'h008, 9'h000, 0, 1);
    chk("R7 R8 link readback", lk_rsp_rdata, 32'h12340002);

    // R6 R7: local write into function 1 word 2
    lm_op(0, 1, 12'h008, 9'h101, 32'hFFFFFFFF, lat, q);
    lm_op(1, 0, 12'h008, 9'h101, 0, lat, q);
    chk("R6 R7 func write", q, 32'h5AFFFF02);
    chk("R5 rdata held", lm_rdata, 32'h5AFFFF02);

    // R6: function out of range; R2: word out of range
    lm_op(1, 0, 12'h004, 9'h109, 0, lat, q);
    chk("R6 func oob", q, 32'h0);
    lm_op(1, 0, 12'h0A0, 9'h000, 0, lat, q);
    chk("R2 word oob", q, 32'h0);

    // R3: deferral behind a 4-cycle link burst
    fork
      lk_op(0, 12'h004, 9'h000, 0, 4);
      lm_op(1, 0, 12'h014, 9'h000, 0, lat, q);
    join
    chk("R3 deferred latency", lat, 5);
    chk("R3 deferred data", q, 32'hC0DE0005);

    // R9: a write enable while busy is ignored
    fork
      lk_op(0, 12'h004, 9'h000, 0, 4);
      lm_op(1, 0, 12'h018, 9'h000, 0, lat, q);
      begin
        @(negedge clk); @(negedge clk);
        lm_wr_en = 1; lm_addr = 12'h00C; lm_sel = 0; lm_wdata = 0;
        @(negedge clk);
        lm_wr_en = 0;
      end
    join
    lm_op(1, 0, 12'h00C, 9'h000, 0, lat, q);
    chk("R9 ignored write", q, 32'hC0DE0003);

    // R10: both enables act as a write
    lm_op(1, 1, 12'h004, 9'h000, 32'h00001234, lat, q);
    chk("R10 rdata unchanged", q, 32'hC0DE0003);
    lm_op(1, 0, 12'h004, 9'h000, 0, lat, q);
    chk("R10 write took", q, 32'hC0DE1234);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule